// File: doc/BRIEF.md
# Serial Line Receiver with Break Handling

This block receives asynchronous serial characters on a single input line. Each character has a low start bit, eight data bits sent least significant bit first, an optional parity bit and one high stop bit. A clock divider makes a 16x oversampling tick. Each bit is resolved by a majority vote over three mid-bit samples. Characters that arrive without error go into a 16-entry receive FIFO, and a consumer pops them one at a time.

A held-low line, also called a break, is handled as its own case. Such a frame fails its stop bit, so the framing-error flag is set, and the parity-error flag may be set as well, depending on the parity setting. The block then enters a break state. In that state the receive state machine keeps cycling through frames, but nothing is written into the FIFO. The state lasts until the receiver is idle and the line has been high for a whole bit time. The synchronised line level is also available as an output, so that software can tell a plain framing error apart from a line that is still held low.

Top module: `uart_brk_rx`

## Requirements
- R1: After reset, `fifo_empty` is 1, `brk_active` is 0, all four flags are 0 and `rxd_level` is 1. `rxd_level` shows the value `rxd` had two clock edges earlier.
- R2: A frame is one low start bit, eight data bits with bit 0 first, a parity bit only when `par_en` is 1, and one stop bit. Each bit lasts 16 ticks. When such a frame has a high stop bit and correct parity, its data byte is pushed into the FIFO.
- R3: The start bit is confirmed by a majority vote of tick samples 7, 8 and 9, counted from 0 at the tick that first sees the line low. If the vote reads high, the receiver returns to idle. It pushes nothing and sets no flag.
- R4: The parity bit is checked against even parity when `par_odd` is 0 and against odd parity when `par_odd` is 1. A mismatch sets `per_flag`, and the character is not pushed.
- R5: A stop bit voted low sets `fer_flag`, and the character is not pushed.
- R6: A frame that has a framing error and all-zero data sets `brk_flag` and `brk_active`. With odd parity enabled, such a frame also sets `per_flag`. With even parity enabled, it does not set `per_flag`.
- R7: While `brk_active` is 1, nothing is written into the FIFO. The receiver keeps framing, and it accepts characters again once the break has ended.
- R8: `brk_active` returns to 0 only when the receiver is idle and the line has been sampled high for 16 consecutive ticks. A shorter high stretch leaves it at 1.
- R9: The FIFO keeps arrival order. A pulse on `rd_en` while the FIFO is not empty gives `rd_valid`=1 with the oldest byte on `rd_data` one clock later. A pulse on `rd_en` while the FIFO is empty gives no `rd_valid`.
- R10: A character that arrives while the FIFO holds 16 entries is dropped, and `ovr_flag` is set. The 16 stored entries are kept.
- R11: `fer_flag`, `per_flag`, `ovr_flag` and `brk_flag` stay set until a one-cycle `clr_err` pulse, which clears them at the next edge. A flag that is being set in the same cycle as the pulse stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial receive line, idle high |
| par_en | input | 1 | 1 = frame carries a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_en | input | 1 | Pop one byte from the FIFO |
| clr_err | input | 1 | One-cycle clear of all sticky flags |
| rd_data | output | 8 | Popped byte, valid with rd_valid |
| rd_valid | output | 1 | rd_data carries a popped byte |
| fifo_empty | output | 1 | FIFO holds no entries |
| fifo_full | output | 1 | FIFO holds 16 entries |
| rxd_level | output | 1 | Synchronised live level of rxd |
| fer_flag | output | 1 | Sticky framing error |
| per_flag | output | 1 | Sticky parity error |
| ovr_flag | output | 1 | Sticky FIFO overrun |
| brk_flag | output | 1 | Sticky break detected |
| brk_active | output | 1 | Break state in progress |

## Verification
The bench targets the end of a break. It first releases the line for only ten ticks, then releases it for good, in the middle of whatever frame the receiver is tracking. A design that ends the break on any rising edge would clear `brk_active` too early. A design that ignores whether the receiver is idle would push the garbage byte that the line release creates. Short low glitches check that the start vote rejects noise instead of framing a byte of ones. A 17-frame burst checks that an overrun drops the newest byte rather than overwriting the oldest. Breaks under odd and under even parity check that the parity flag follows the configured sense on all-zero data.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_t;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              fer;
    logic              per;
    logic              zero;
  } rx_frame_t;
endpackage

// File: rtl/brk_baud_div.sv
module brk_baud_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
      tick <= (cnt == LAST);
    end
  end
endmodule

// File: rtl/brk_rx_fsm.sv
module brk_rx_fsm
  import uart_brk_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      rxd_s,
  input  logic      par_en,
  input  logic      par_odd,
  output logic      done,
  output rx_frame_t frame,
  output logic      idle
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DATA_W);
  localparam logic [CW-1:0] SP_A = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] SP_B = CW'(OVS / 2);
  localparam logic [CW-1:0] SP_C = CW'(OVS / 2 + 1);
  localparam logic [CW-1:0] C_END = CW'(OVS - 1);
  localparam logic [BW-1:0] B_END = BW'(DATA_W - 1);

  rx_state_t         st;
  logic [CW-1:0]     cnt;
  logic [1:0]        smp;
  logic [DATA_W-1:0] sh;
  logic [BW-1:0]     bidx;
  logic              pbit;
  logic              vote;

  assign vote = (smp[0] & smp[1]) | (smp[0] & rxd_s) | (smp[1] & rxd_s);
  assign idle = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      smp   <= 2'b11;
      sh    <= '0;
      bidx  <= '0;
      pbit  <= 1'b0;
      done  <= 1'b0;
      frame <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        if (st == ST_IDLE) begin
          if (!rxd_s) begin
            st  <= ST_START;
            cnt <= '0;
          end
        end else begin
          cnt <= (cnt == C_END) ? '0 : cnt + 1'b1;
          if (cnt == SP_A) smp[0] <= rxd_s;
          if (cnt == SP_B) smp[1] <= rxd_s;
          if (cnt == SP_C) begin
            unique case (st)
              ST_START: if (vote) st <= ST_IDLE;
              ST_DATA:  sh <= {vote, sh[DATA_W-1:1]};
              ST_PAR:   pbit <= vote;
              ST_STOP: begin
                done       <= 1'b1;
                frame.data <= sh;
                frame.fer  <= ~vote;
                frame.per  <= par_en & ((^sh ^ pbit) != par_odd);
                frame.zero <= (sh == '0);
                st         <= ST_IDLE;
              end
              default: ;
            endcase
          end
          if (cnt == C_END) begin
            unique case (st)
              ST_START: begin
                st   <= ST_DATA;
                bidx <= '0;
              end
              ST_DATA: begin
                if (bidx == B_END) st <= par_en ? ST_PAR : ST_STOP;
                else bidx <= bidx + 1'b1;
              end
              ST_PAR: st <= ST_STOP;
              default: ;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/brk_rx_fifo.sv
module brk_rx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic          full,
  output logic          empty,
  output logic          drop
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wr_ptr, rd_ptr;
  logic          do_wr, do_rd;

  assign empty = (wr_ptr == rd_ptr);
  assign full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign do_wr = push & ~full;
  assign do_rd = pop & ~empty;
  assign drop  = push & full;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr[AW-1:0]] <= wdata;
    if (do_rd) rdata <= mem[rd_ptr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      rvalid <= 1'b0;
    end else begin
      if (do_wr) wr_ptr <= wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= rd_ptr + 1'b1;
      rvalid <= do_rd;
    end
  end
endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx
  import uart_brk_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int OVS        = 16,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxd,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rd_en,
  input  logic              clr_err,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              fifo_empty,
  output logic              fifo_full,
  output logic              rxd_level,
  output logic              fer_flag,
  output logic              per_flag,
  output logic              ovr_flag,
  output logic              brk_flag,
  output logic              brk_active
);
  localparam int HW = $clog2(OVS + 1);
  localparam logic [HW-1:0] HI_MAX = HW'(OVS);

  logic      tick, rxd_m, rxd_s;
  logic      frm_done, rx_idle, push, drop, brk_hit;
  rx_frame_t frm;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rxd_m <= 1'b1;
      rxd_s <= 1'b1;
    end else begin
      rxd_m <= rxd;
      rxd_s <= rxd_m;
    end
  end
  assign rxd_level = rxd_s;

  brk_baud_div #(.DIV(CLK_DIV)) u_div (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  brk_rx_fsm #(.OVS(OVS)) u_fsm (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .rxd_s  (rxd_s),
    .par_en (par_en),
    .par_odd(par_odd),
    .done   (frm_done),
    .frame  (frm),
    .idle   (rx_idle)
  );

  assign brk_hit = frm_done & frm.fer & frm.zero;
  assign push    = frm_done & ~frm.fer & ~frm.per & ~brk_active;

  brk_rx_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .wdata (frm.data),
    .pop   (rd_en),
    .rdata (rd_data),
    .rvalid(rd_valid),
    .full  (fifo_full),
    .empty (fifo_empty),
    .drop  (drop)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt     <= '0;
      brk_active <= 1'b0;
      fer_flag   <= 1'b0;
      per_flag   <= 1'b0;
      ovr_flag   <= 1'b0;
      brk_flag   <= 1'b0;
    end else begin
      if (tick) begin
        if (!rxd_s) hi_cnt <= '0;
        else if (hi_cnt != HI_MAX) hi_cnt <= hi_cnt + 1'b1;
      end
      if (brk_hit) brk_active <= 1'b1;
      else if (brk_active && rx_idle && hi_cnt == HI_MAX) brk_active <= 1'b0;
      fer_flag <= (fer_flag & ~clr_err) | (frm_done & frm.fer);
      per_flag <= (per_flag & ~clr_err) | (frm_done & frm.per);
      ovr_flag <= (ovr_flag & ~clr_err) | drop;
      brk_flag <= (brk_flag & ~clr_err) | brk_hit;
    end
  end
endmodule

// File: rtl/uart_brk_rx_chk.sv
module uart_brk_rx_chk (
  input logic clk,
  input logic rst,
  input logic clr_err,
  input logic rd_en,
  input logic push,
  input logic frm_done,
  input logic fifo_full,
  input logic fifo_empty,
  input logic rd_valid,
  input logic brk_active,
  input logic fer_flag,
  input logic per_flag,
  input logic ovr_flag,
  input logic brk_flag
);
  AST_NO_WRITE_IN_BREAK: assert property (@(posedge clk) disable iff (rst)
    brk_active && fifo_empty |=> fifo_empty); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    fifo_full && !rd_en |=> fifo_full); // R10
  AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (rst)
    fifo_full && push |=> ovr_flag); // R10
  AST_FER_STICKY: assert property (@(posedge clk) disable iff (rst)
    fer_flag && !clr_err |=> fer_flag); // R11
  AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (rst)
    clr_err && !frm_done |=> !fer_flag && !per_flag && !brk_flag && !ovr_flag); // R11
  AST_BREAK_FRAMING: assert property (@(posedge clk) disable iff (rst)
    $rose(brk_active) |-> fer_flag && brk_flag); // R6
  AST_POP_VALID: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en) && !$past(fifo_empty)); // R9
endmodule

bind uart_brk_rx uart_brk_rx_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .clr_err   (clr_err),
  .rd_en     (rd_en),
  .push      (push),
  .frm_done  (frm_done),
  .fifo_full (fifo_full),
  .fifo_empty(fifo_empty),
  .rd_valid  (rd_valid),
  .brk_active(brk_active),
  .fer_flag  (fer_flag),
  .per_flag  (per_flag),
  .ovr_flag  (ovr_flag),
  .brk_flag  (brk_flag)
);

// File: tb/uart_brk_rx_tb.sv
module uart_brk_rx_tb;
  localparam int DIV = 4;
  localparam int BIT = 16 * DIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxd = 1'b1;
  logic       par_en = 1'b0, par_odd = 1'b0, rd_en = 1'b0, clr_err = 1'b0;
  logic [7:0] rd_data;
  logic       rd_valid, fifo_empty, fifo_full, rxd_level;
  logic       fer_flag, per_flag, ovr_flag, brk_flag, brk_active;

  int n_chk = 0;
  int n_bad = 0;
  bit done_run = 0;

  always #4 clk = ~clk;

  uart_brk_rx #(.CLK_DIV(DIV), .OVS(16), .FIFO_DEPTH(16)) u_dut (
    .clk(clk), .rst(rst), .rxd(rxd), .par_en(par_en), .par_odd(par_odd),
    .rd_en(rd_en), .clr_err(clr_err), .rd_data(rd_data), .rd_valid(rd_valid),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .rxd_level(rxd_level),
    .fer_flag(fer_flag), .per_flag(per_flag), .ovr_flag(ovr_flag),
    .brk_flag(brk_flag), .brk_active(brk_active)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit par_bit(input logic [7:0] d, input bit odd);
    return (^d) ^ odd;
  endfunction

  function automatic bit exp_good(input bit pe, input bit flip, input bit stop);
    return stop && !(pe && flip);
  endfunction

  task automatic send_frame(input logic [7:0] d, input bit pe, input bit po,
                            input bit flip, input bit stop);
    par_en = pe; par_odd = po;
    rxd = 1'b0; wait_clk(BIT);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i]; wait_clk(BIT);
    end
    if (pe) begin
      rxd = par_bit(d, po) ^ flip; wait_clk(BIT);
    end
    rxd = stop; wait_clk(BIT);
    rxd = 1'b1; wait_clk(2 * BIT);
  endtask

  task automatic pop(output logic [7:0] d, output bit v);
    rd_en = 1'b1; wait_clk(1);
    rd_en = 1'b0;
    v = rd_valid; d = rd_data;
    wait_clk(1);
  endtask

  task automatic clear_flags();
    clr_err = 1'b1; wait_clk(1);
    clr_err = 1'b0; wait_clk(1);
  endtask

  task automatic finish_run();
    if (!done_run) begin
      done_run = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    bit v;
    int seed;
    seed = $urandom(32'h5EED);
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);

    // R1 reset state
    chk(fifo_empty && !brk_active, "R1 reset fifo/brk", {fifo_empty, brk_active}, 2'b10);
    chk({fer_flag, per_flag, ovr_flag, brk_flag} == 4'b0, "R1 reset flags",
        {fer_flag, per_flag, ovr_flag, brk_flag}, 0);
    chk(rxd_level == 1'b1, "R1 rxd_level idle", rxd_level, 1);

    // R1 level latency, R3 short glitch rejected
    rxd = 1'b0; wait_clk(1);
    chk(rxd_level == 1'b1, "R1 level after one edge", rxd_level, 1);
    wait_clk(1);
    chk(rxd_level == 1'b0, "R1 level after two edges", rxd_level, 0);
    rxd = 1'b1; wait_clk(2 * BIT);
    chk(fifo_empty && !fer_flag, "R3 short glitch", {fifo_empty, fer_flag}, 2'b10);
    rxd = 1'b0; wait_clk(5 * DIV);
    rxd = 1'b1; wait_clk(2 * BIT);
    chk(fifo_empty && !fer_flag && !per_flag, "R3 five-tick glitch",
        {fifo_empty, fer_flag, per_flag}, 3'b100);

    // R9 pop when empty
    pop(d, v);
    chk(!v, "R9 pop empty", v, 0);

    // R2 directed frame
    send_frame(8'hA5, 0, 0, 0, 1);
    pop(d, v);
    chk(v && d == 8'hA5, "R2 directed byte", {v, d}, {1'b1, 8'hA5});

    // R2 R4 R5 random frames
    for (int k = 0; k < 24; k++) begin
      logic [7:0] rd;
      bit pe, po, fl, st;
      rd = 8'($urandom); pe = 1'($urandom); po = 1'($urandom);
      fl = ($urandom % 5) == 0; st = ($urandom % 6) != 0;
      send_frame(rd, pe, po, fl, st);
      chk(fer_flag == !st, "R5 framing flag", fer_flag, !st);
      chk(per_flag == (pe && fl), "R4 parity flag", per_flag, pe && fl);
      chk(brk_flag == (!st && rd == 8'h00), "R6 break only on zero data", brk_flag,
          !st && rd == 8'h00);
      if (exp_good(pe, fl, st)) begin
        pop(d, v);
        chk(v && d == rd, "R2 random byte", {v, d}, {1'b1, rd});
      end else begin
        chk(fifo_empty, "R4 R5 bad frame not stored", fifo_empty, 1);
      end
      if (brk_active) wait_clk(4 * BIT);
      clear_flags();
    end

    // R11 sticky then cleared
    send_frame(8'h3C, 0, 0, 0, 0);
    wait_clk(3 * BIT);
    chk(fer_flag, "R11 framing flag held", fer_flag, 1);
    clr_err = 1'b1; wait_clk(1);
    clr_err = 1'b0;
    chk(!fer_flag, "R11 cleared by pulse", fer_flag, 0);
    wait_clk(BIT);

    // R10 overrun
    for (int k = 0; k < 17; k++) send_frame(8'(k * 7 + 3), 0, 0, 0, 1);
    chk(fifo_full && ovr_flag, "R10 full and overrun", {fifo_full, ovr_flag}, 2'b11);
    for (int k = 0; k < 16; k++) begin
      pop(d, v);
      chk(v && d == 8'(k * 7 + 3), "R9 R10 order kept", {v, d}, {1'b1, 8'(k * 7 + 3)});
    end
    chk(fifo_empty, "R10 newest dropped", fifo_empty, 1);
    clear_flags();

    // R6 R7 R8 break with odd parity
    par_en = 1'b1; par_odd = 1'b1;
    rxd = 1'b0; wait_clk(25 * BIT);
    chk(brk_active && brk_flag, "R6 break seen", {brk_active, brk_flag}, 2'b11);
    chk(fer_flag && per_flag, "R6 fer and odd per", {fer_flag, per_flag}, 2'b11);
    chk(fifo_empty, "R7 no write in break", fifo_empty, 1);
    rxd = 1'b1; wait_clk(10 * DIV);
    rxd = 1'b0; wait_clk(4 * BIT);
    chk(brk_active, "R8 short high keeps break", brk_active, 1);
    rxd = 1'b1; wait_clk(40 * BIT);
    chk(!brk_active, "R8 break ended", brk_active, 0);
    chk(fifo_empty, "R7 release byte dropped", fifo_empty, 1);
    clear_flags();
    send_frame(8'h69, 1, 1, 0, 1);
    pop(d, v);
    chk(v && d == 8'h69, "R7 resumes after break", {v, d}, {1'b1, 8'h69});

    // R6 break with even parity
    par_en = 1'b1; par_odd = 1'b0;
    rxd = 1'b0; wait_clk(14 * BIT);
    chk(brk_active && fer_flag && !per_flag, "R6 even parity break",
        {brk_active, fer_flag, per_flag}, 3'b110);
    rxd = 1'b1; wait_clk(30 * BIT);
    chk(!brk_active && fifo_empty, "R8 R7 second release",
        {brk_active, fifo_empty}, 2'b01);

    finish_run();
  end
endmodule